// File: doc/BRIEF.md
# SD Command Issue and Response Capture Unit

This block lets a host issue SD card commands through a small word-addressed register interface and keeps the card's answer for later reads. The host stores a 32-bit argument, then writes a 16-bit command word. When the launch bit of that word is set, the unit presents the command index and the stored argument to a card-side agent over a valid/ready request channel. It then waits on a valid/ready response channel, which returns a length of 0, 4 or 16 bytes, a data field and an error flag.

The unit checks the returned length against the command's response flags. It stores an accepted response in four 32-bit response registers. A failure is recorded in both the command word and a write-one-to-clear status register. A single level interrupt follows the interrupt-class status bits one cycle late. The host can write the timeout and clock-divide registers, but they hold nothing and read as zero.

Back-pressure rules: once `req_valid` rises, it and the request fields stay unchanged until a cycle with `req_ready` high. `rsp_ready` is high only while a request is outstanding and its request handshake is complete. A response is taken in the first cycle where `rsp_valid` and `rsp_ready` are both high, and `rsp_valid` has no effect at any other time.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is low and `req_valid` is low.
- R2: A command write with bit 15 set, made while no command is outstanding, raises `req_valid` on the next cycle. `req_index` carries command bits 5:0 and `req_arg` carries the argument register as it stood before that write. Both stay stable until `req_ready`. A command write with bit 15 clear only stores the word.
- R3: Once the response handshake completes, bit 15 of the stored command word reads zero and its other bits keep their values. Command writes made while a command is outstanding are ignored.
- R4: With command bit 10 (no response) clear, the command fails if the returned length is 0, or 4 while bit 9 (long response) is set, or anything other than 4 or 16. A set `rsp_err` fails the command in every case.
- R5: A failed command sets command bit 14 and status bit 6, and leaves the response registers unchanged.
- R6: On a successful 4-byte response, response word 0 holds bytes 0..3 with byte 0 as its most significant byte, and words 1 to 3 read zero. Byte k of `rsp_data` sits at bits 127-8k down to 120-8k.
- R7: On a successful 16-byte response, word 3 holds bytes 0..3, word 2 bytes 4..7, word 1 bytes 8..11 and word 0 bytes 12..15, each with its first byte as the most significant.
- R8: With command bit 10 set, a response of any length and without error succeeds and leaves the response registers unchanged.
- R9: Status bit 10 is set when a command succeeds with command bit 11 (busy-wait) set and configuration bit 10 set. It is not set on failure or when configuration bit 10 is clear.
- R10: A status write clears exactly the bits written as one. A completion that sets a status bit in the same cycle takes priority over the clear.
- R11: `irq` is high exactly when any of status bits 10, 9 or 8 was set in the previous cycle.
- R12: Writes to the timeout (address 2) and clock-divide (address 3) registers change no other register, and both addresses read zero. Addresses: 0 command, 1 argument, 4 to 7 response words 0 to 3, 8 status, 9 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Card agent accepts request |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Card response valid |
| rsp_ready | output | 1 | Unit accepts a response |
| rsp_len | input | 5 | Response length in bytes |
| rsp_err | input | 1 | Card-side error |
| rsp_data | input | 128 | Response bytes, byte 0 most significant |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the card agent keeps `rsp_len`, `rsp_err` and `rsp_data` valid during the response handshake cycle. They also assume that the host writes the status register in no cycle where a response completes. The stimulus meets both assumptions by driving the response fields and `rsp_valid` together for a single cycle, and it issues status writes only after a command's task has returned. Request back-pressure is exercised by holding `req_ready` low for several cycles. A command write is inserted during that time to confirm it is ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_W     = 16;
  localparam int IDX_W     = 6;
  localparam int STAT_W    = 11;
  // command word fields
  localparam int B_LONG    = 9;
  localparam int B_NORSP   = 10;
  localparam int B_BUSYW   = 11;
  localparam int B_FAIL    = 14;
  localparam int B_NEW     = 15;
  // status and configuration fields
  localparam int S_TIMEOUT = 6;
  localparam int S_IRQ_LO  = 8;
  localparam int S_BUSY    = 10;
  localparam int C_BUSY_EN = 10;
  // register word addresses
  localparam int A_CMD  = 0;
  localparam int A_ARG  = 1;
  localparam int A_TOUT = 2;
  localparam int A_CDIV = 3;
  localparam int A_RSP0 = 4;
  localparam int A_STAT = 8;
  localparam int A_CFG  = 9;

  typedef enum logic [1:0] {HS_IDLE, HS_REQ, HS_WAIT} hs_state_t;
endpackage

// File: rtl/sdc_handshake.sv
module sdc_handshake
  import sdc_pkg::*;
#(
  parameter int IW = 6,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [IW-1:0] launch_idx,
  input  logic [AW-1:0] launch_arg,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [IW-1:0] req_index,
  output logic [AW-1:0] req_arg,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          busy,
  output logic          done
);
  hs_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= HS_IDLE;
      req_index <= '0;
      req_arg   <= '0;
    end else begin
      case (st)
        HS_IDLE: if (launch) begin
          st        <= HS_REQ;
          req_index <= launch_idx;
          req_arg   <= launch_arg;
        end
        HS_REQ:  if (req_ready) st <= HS_WAIT;
        HS_WAIT: if (rsp_valid) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign req_valid = (st == HS_REQ);
  assign rsp_ready = (st == HS_WAIT);
  assign busy      = (st != HS_IDLE);
  assign done      = rsp_ready && rsp_valid;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));
endmodule

// File: rtl/sdc_rsp_check.sv
module sdc_rsp_check
  import sdc_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int WW    = 32,
  localparam int NBYTES = WORDS * WW / 8,
  localparam int LW     = $clog2(NBYTES + 1)
) (
  input  logic                      no_rsp,
  input  logic                      long_rsp,
  input  logic [LW-1:0]             rsp_len,
  input  logic                      rsp_err,
  input  logic [8*NBYTES-1:0]       rsp_data,
  output logic                      fail,
  output logic                      load,
  output logic [WORDS-1:0][WW-1:0]  words
);
  localparam int SHORT_LEN = WW / 8;

  logic is_short, is_long, bad_len;
  assign is_short = (rsp_len == LW'(SHORT_LEN));
  assign is_long  = (rsp_len == LW'(NBYTES));
  assign bad_len  = (rsp_len == '0) || (is_short && long_rsp) || (!is_short && !is_long);
  assign fail     = rsp_err || (!no_rsp && bad_len);
  assign load     = !fail && !no_rsp;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == 0) begin : g_first
      assign words[w] = is_short ? rsp_data[8*NBYTES-1 -: WW] : rsp_data[w*WW +: WW];
    end else begin : g_rest
      assign words[w] = is_short ? '0 : rsp_data[w*WW +: WW];
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sdc_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 32,
  parameter int RSP_WORDS = 4,
  localparam int RSP_BYTES = RSP_WORDS * DW / 8,
  localparam int LW        = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [IDX_W-1:0]       req_index,
  output logic [DW-1:0]          req_arg,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [LW-1:0]          rsp_len,
  input  logic                   rsp_err,
  input  logic [8*RSP_BYTES-1:0] rsp_data,
  output logic                   irq
);
  logic [CMD_W-1:0]               cmd_q;
  logic [DW-1:0]                  arg_q, cfg_q;
  logic [STAT_W-1:0]              stat_q, stat_n;
  logic [RSP_WORDS-1:0][DW-1:0]   rsp_q, words;
  logic busy, done, fail, load, wr_cmd, wr_stat, launch;

  assign wr_cmd  = wr_en && (wr_addr == AW'(A_CMD)) && !busy;
  assign wr_stat = wr_en && (wr_addr == AW'(A_STAT));
  assign launch  = wr_cmd && wr_data[B_NEW];

  sdc_handshake #(.IW(IDX_W), .AW(DW)) u_hs (
    .clk, .rst_n, .launch,
    .launch_idx(wr_data[IDX_W-1:0]), .launch_arg(arg_q),
    .req_valid, .req_ready, .req_index, .req_arg,
    .rsp_valid, .rsp_ready, .busy, .done
  );

  sdc_rsp_check #(.WORDS(RSP_WORDS), .WW(DW)) u_chk (
    .no_rsp(cmd_q[B_NORSP]), .long_rsp(cmd_q[B_LONG]),
    .rsp_len, .rsp_err, .rsp_data, .fail, .load, .words
  );

  always_comb begin
    stat_n = stat_q;
    if (wr_stat) stat_n = stat_q & ~wr_data[STAT_W-1:0];
    if (done && fail) stat_n[S_TIMEOUT] = 1'b1;
    if (done && !fail && cmd_q[B_BUSYW] && cfg_q[C_BUSY_EN]) stat_n[S_BUSY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      arg_q  <= '0;
      cfg_q  <= '0;
      stat_q <= '0;
      rsp_q  <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      irq    <= |stat_q[S_BUSY:S_IRQ_LO];
      if (wr_cmd) cmd_q <= wr_data[CMD_W-1:0];
      else if (done) begin
        cmd_q[B_NEW] <= 1'b0;
        if (fail) cmd_q[B_FAIL] <= 1'b1;
      end
      if (wr_en && wr_addr == AW'(A_ARG)) arg_q <= wr_data;
      if (wr_en && wr_addr == AW'(A_CFG)) cfg_q <= wr_data;
      if (done && load) rsp_q <= words;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CMD))  rd_data = DW'(cmd_q);
    if (rd_addr == AW'(A_ARG))  rd_data = arg_q;
    if (rd_addr == AW'(A_STAT)) rd_data = DW'(stat_q);
    if (rd_addr == AW'(A_CFG))  rd_data = cfg_q;
    for (int w = 0; w < RSP_WORDS; w++)
      if (rd_addr == AW'(A_RSP0 + w)) rd_data = rsp_q[w];
  end

  assert_new_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cmd_q[B_NEW]);
  assert_fail_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |=> (cmd_q[B_FAIL] && stat_q[S_TIMEOUT]));
  assert_fail_keeps_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |=> $stable(rsp_q));
  assert_short_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && load && rsp_len == LW'(DW / 8)) |=> (rsp_q[RSP_WORDS-1] == '0));
  assert_no_busy_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail && !wr_stat) |=> $stable(stat_q[S_BUSY]));
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|stat_q[S_BUSY:S_IRQ_LO]));
endmodule

// File: tb/tb_sd_cmd_issue.sv
module tb_sd_cmd_issue;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, req_ready = 0, rsp_valid = 0, rsp_err = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, req_arg;
  logic [5:0] req_index;
  logic [4:0] rsp_len = 0;
  logic [127:0] rsp_data = 0;
  logic req_valid, rsp_ready, irq;
  int checks = 0, bad = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  sd_cmd_issue dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .req_valid, .req_ready, .req_index, .req_arg, .rsp_valid, .rsp_ready,
    .rsp_len, .rsp_err, .rsp_data, .irq);

  // behavioural reference
  int unsigned m_cmd, m_arg, m_cfg, m_stat, m_larg, m_idx;
  int unsigned m_rsp[4];
  int m_st;  // 0 idle, 1 requesting, 2 awaiting answer
  bit m_irq;

  function automatic int unsigned rbyte(int k);
    return int'(rsp_data >> (8 * (15 - k))) & 255;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_arg = 0; m_cfg = 0; m_stat = 0; m_st = 0; m_irq = 0;
      m_larg = 0; m_idx = 0;
      foreach (m_rsp[i]) m_rsp[i] = 0;
    end else begin
      bit fin, badr, nores;
      int unsigned prev_stat, prev_arg;
      prev_stat = m_stat; prev_arg = m_arg;
      fin = (m_st == 2) && rsp_valid;
      nores = m_cmd[10];
      badr = rsp_err || (!nores && (rsp_len == 0 || (rsp_len == 4 && m_cmd[9]) ||
                                   (rsp_len != 4 && rsp_len != 16)));
      if (wr_en && wr_addr == 8) m_stat = m_stat & ~(wr_data & 32'h7FF);
      if (fin) begin
        if (badr) begin
          m_cmd = m_cmd | 32'h4000; m_stat = m_stat | 32'h40;
        end else begin
          if (m_cmd[11] && m_cfg[10]) m_stat = m_stat | 32'h400;
          if (!nores) begin
            if (rsp_len == 4) begin
              m_rsp[0] = 0;
              for (int j = 0; j < 4; j++) m_rsp[0] = (m_rsp[0] << 8) | rbyte(j);
              m_rsp[1] = 0; m_rsp[2] = 0; m_rsp[3] = 0;
            end else begin
              for (int w = 0; w < 4; w++) begin
                m_rsp[w] = 0;
                for (int j = 0; j < 4; j++) m_rsp[w] = (m_rsp[w] << 8) | rbyte((3 - w) * 4 + j);
              end
            end
          end
        end
        m_cmd = m_cmd & ~32'h8000;
      end
      if (wr_en && wr_addr == 1) m_arg = wr_data;
      if (wr_en && wr_addr == 9) m_cfg = wr_data;
      m_irq = (prev_stat & 32'h700) != 0;
      if (m_st == 1 && req_ready) m_st = 2;
      else if (fin) m_st = 0;
      else if (m_st == 0 && wr_en && wr_addr == 0) begin
        m_cmd = wr_data & 32'hFFFF;
        if (wr_data[15]) begin m_st = 1; m_idx = wr_data & 63; m_larg = prev_arg; end
      end
    end
  end

  function automatic int unsigned m_read(logic [3:0] a);
    case (a)
      0: return m_cmd;  1: return m_arg;  8: return m_stat; 9: return m_cfg;
      4, 5, 6, 7: return m_rsp[a - 4];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      0: return "R3"; 8: return "R10"; 2, 3: return "R12";
      4, 5, 6, 7: return "R7"; default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    check("R2", req_valid, m_st == 1);
    check("R3", rsp_ready, m_st == 2);
    if (req_valid) begin check("R2", req_index, m_idx); check("R2", req_arg, m_larg); end
    check("R11", irq, m_irq);
    check(tag_of(rd_addr), rd_data, m_read(rd_addr));
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1 wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic peek(logic [3:0] a, int unsigned exp, string tag);
    @(posedge clk); #1 rd_addr = a;
    @(negedge clk); check(tag, rd_data, exp);
  endtask

  task automatic issue(logic [15:0] c, int unsigned arg, int rdly, logic [4:0] len,
                       logic err, logic [127:0] data, bit poke);
    @(posedge clk); #1 wr_en = 1; wr_addr = 0; wr_data = 32'(c); req_ready = 0;
    @(posedge clk); #1 wr_en = 0;
    if (poke) begin
      wr_en = 1; wr_data = 32'h803F;
      @(posedge clk); #1 wr_en = 0;
    end
    @(negedge clk);
    check("R2", req_valid, 1); check("R2", req_index, c[5:0]); check("R2", req_arg, arg);
    repeat (rdly) @(posedge clk);
    #1 req_ready = 1;
    @(posedge clk); #1 req_ready = 0;
    rsp_valid = 1; rsp_len = len; rsp_err = err; rsp_data = data;
    @(posedge clk); #1 rsp_valid = 0; rsp_err = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; cmp_on = 1;
    for (int a = 0; a < 10; a++) peek(4'(a), 0, "R1");
    @(negedge clk); check("R1", irq, 0); check("R1", req_valid, 0);

    wr(1, 32'hDEADBEEF);
    issue(16'h8011, 32'hDEADBEEF, 3, 4, 0, {32'h12345678, 96'h9ABCDEF0_11111111_22222222}, 1);
    peek(0, 32'h0011, "R3");
    peek(4, 32'h12345678, "R6"); peek(5, 0, "R6"); peek(7, 0, "R6");

    wr(1, 1);
    issue(16'h8202, 1, 0, 16, 0, 128'h00112233_44556677_8899AABB_CCDDEEFF, 0);
    peek(4, 32'hCCDDEEFF, "R7"); peek(5, 32'h8899AABB, "R7");
    peek(6, 32'h44556677, "R7"); peek(7, 32'h00112233, "R7");

    issue(16'h8203, 1, 1, 4, 0, '1, 0);
    peek(0, 32'h4203, "R4"); peek(8, 32'h40, "R5"); peek(4, 32'hCCDDEEFF, "R5");
    @(negedge clk); check("R11", irq, 0);
    wr(8, 32'h40); peek(8, 0, "R10");

    issue(16'h8004, 1, 0, 0, 0, '1, 0);
    peek(0, 32'h4004, "R4"); wr(8, 32'h40);
    issue(16'h8005, 1, 0, 8, 0, '1, 0);
    peek(0, 32'h4005, "R4"); wr(8, 32'h40);
    issue(16'h8406, 1, 0, 0, 1, '1, 0);
    peek(0, 32'h4406, "R4"); peek(8, 32'h40, "R4"); wr(8, 32'h40);

    issue(16'h8607, 1, 0, 4, 0, '1, 0);
    peek(0, 32'h0607, "R8"); peek(4, 32'hCCDDEEFF, "R8"); peek(7, 32'h00112233, "R8");

    wr(9, 32'h400);
    issue(16'h8809, 1, 0, 0, 0, '1, 0);
    peek(8, 32'h40, "R9");
    issue(16'h8C08, 1, 0, 0, 0, '1, 0);
    @(negedge clk); check("R11", irq, 1);
    peek(8, 32'h440, "R9");
    wr(8, 32'h40); peek(8, 32'h400, "R10");
    wr(8, 32'h400);
    @(negedge clk); check("R11", irq, 1);
    peek(8, 0, "R10");
    check("R11", irq, 0);

    wr(9, 0);
    issue(16'h8C0A, 1, 0, 0, 0, '1, 0);
    peek(8, 0, "R9");

    wr(2, 32'hFFFFFFFF); wr(3, 32'hFFFFFFFF);
    peek(2, 0, "R12"); peek(3, 0, "R12"); peek(0, 32'h0C0A, "R12");
    peek(1, 1, "R12"); peek(9, 0, "R12");

    wr(0, 32'h00C1);
    @(negedge clk); check("R2", req_valid, 0);
    peek(0, 32'h00C1, "R2");

    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule